// File: doc/BRIEF.md
# Eight-Channel Memory-to-Port Block Copier

The block copies runs of bytes from a 24-bit main-bus source address to a numbered port on a narrow 8-bit peripheral bus. It has eight channels. Software sets each one up through seven byte-wide registers: a pattern field, a base port number, a three-byte source address and a two-byte count. A single write to the arm register then starts every channel whose bit is set.

While a burst runs, the engine holds the processor stopped through `halt`. It moves one byte in each slot of `CLKS_PER_BYTE` master clocks and services the armed channels one after another, starting with the lowest index. In each slot the engine issues one read strobe on the main bus and one write strobe on the port bus, in the same cycle. The byte read passes straight to the port. The pattern field sets how the bytes of a channel are spread over the base port and the port above it.

Top module: `bdma_engine`

## Requirements
- R1: After reset `halt` is 0, `armed` is 0 and neither `src_rd` nor `port_we` is asserted.
- R2: The register write selects a channel with `cfg_ch` and a register with `cfg_ofs`. The registers are: 0 is the pattern (bits 2:0 are kept, the other bits are dropped), 1 is the base port, 2, 3 and 4 are source bits 7:0, 15:8 and 23:16, and 5 and 6 are count bits 7:0 and 15:8. A write to offset 7 has no effect.
- R3: An arm write with a nonzero mask while idle loads `armed` with the mask and raises `halt` on the next cycle. The first byte is strobed in that first halted cycle.
- R4: While halted, the engine strobes one byte every `CLKS_PER_BYTE` (default 8) cycles. Byte k of a burst comes exactly k·8 cycles after the first. `port_wdata` carries `src_rdata` of the same cycle.
- R5: `halt` stays high for exactly 8 × (total bytes of all armed channels) cycles. It drops on the clock that follows the last slot.
- R6: Armed channels run in order of rising index. Each channel finishes before the next begins, with no idle slot between them.
- R7: A channel's `armed` bit clears at the end of its last slot, and the other bits keep their state.
- R8: Source bits 15:0 rise by one per byte and wrap from FFFF to 0000. Source bits 23:16 never change.
- R9: With pattern 1, a channel's bytes alternate between the base port and base+1 (modulo 256), and each channel starts again on its base port. With any other pattern value, every byte goes to the base port.
- R10: A count of 0 moves 65536 bytes.
- R11: Register writes and arm writes made while `halt` is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Channel register write strobe |
| cfg_ch | input | 3 | Channel selected for the write |
| cfg_ofs | input | 3 | Register offset within the channel |
| cfg_wdata | input | 8 | Write data |
| arm_we | input | 1 | Arm register write strobe |
| arm_mask | input | 8 | One bit per channel to arm |
| halt | output | 1 | Processor stall, high for the whole burst |
| armed | output | 8 | Channels still pending or running |
| src_rd | output | 1 | Main-bus read strobe |
| src_addr | output | 24 | Main-bus source address |
| src_rdata | input | 8 | Byte returned for `src_addr` in the same cycle |
| port_we | output | 1 | Port-bus write strobe |
| port_idx | output | 8 | Destination port number |
| port_wdata | output | 8 | Byte written to the port |

## Verification
An arm write sampled at an edge produces its first strobe in the cycle that follows that edge. Byte k of the burst is due 8·k cycles after that, and `halt` is low again 8·N cycles after the arm edge. The driver stamps every expected byte with the bench cycle number at which it is due. The monitor samples on falling edges and compares the cycle number as well as the port, address and data. The arm-bit schedule and the halt length are checked cycle by cycle against the end slot of each channel. The 65536-byte case runs on a second instance with a two-clock slot, so that it fits the run length.

// File: rtl/bdma_pkg.sv
package bdma_pkg;

   localparam int PAT_W = 3;

   localparam logic [2:0] OFS_PAT     = 3'd0;
   localparam logic [2:0] OFS_PORT    = 3'd1;
   localparam logic [2:0] OFS_SRC_LO  = 3'd2;
   localparam logic [2:0] OFS_SRC_MID = 3'd3;
   localparam logic [2:0] OFS_SRC_BNK = 3'd4;
   localparam logic [2:0] OFS_CNT_LO  = 3'd5;
   localparam logic [2:0] OFS_CNT_HI  = 3'd6;

   localparam logic [PAT_W-1:0] PAT_ALTERNATE = 3'd1;

   // per-channel register set; count 0 stands for 65536 bytes
   typedef struct packed {
      logic [PAT_W-1:0] pat;
      logic [7:0]       port;
      logic [23:0]      src;
      logic [15:0]      cnt;
   } chan_regs_t;

endpackage

// File: rtl/bdma_regbank.sv
module bdma_regbank
   import bdma_pkg::*;
#(
   parameter int NUM_CH = 8,
   localparam int CH_W = $clog2(NUM_CH)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [CH_W-1:0]          wr_ch,
   input  logic [2:0]               wr_ofs,
   input  logic [7:0]               wr_data,
   input  logic                     step_en,
   input  logic [CH_W-1:0]          step_ch,
   output chan_regs_t [NUM_CH-1:0]  regs
);

   for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
      chan_regs_t r;
      logic       hit_step;
      logic       hit_wr;

      assign hit_step = step_en && (step_ch == CH_W'(g));
      assign hit_wr   = wr_en && (wr_ch == CH_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            r <= '0;
         end else if (hit_step) begin
            // advance within the bank, bank byte untouched
            r.src[15:0] <= r.src[15:0] + 16'd1;
            r.cnt       <= r.cnt - 16'd1;
         end else if (hit_wr) begin
            case (wr_ofs)
               OFS_PAT:     r.pat        <= wr_data[PAT_W-1:0];
               OFS_PORT:    r.port       <= wr_data;
               OFS_SRC_LO:  r.src[7:0]   <= wr_data;
               OFS_SRC_MID: r.src[15:8]  <= wr_data;
               OFS_SRC_BNK: r.src[23:16] <= wr_data;
               OFS_CNT_LO:  r.cnt[7:0]   <= wr_data;
               OFS_CNT_HI:  r.cnt[15:8]  <= wr_data;
               default:     r            <= r;
            endcase
         end
      end

      assign regs[g] = r;
   end

endmodule

// File: rtl/bdma_seq.sv
module bdma_seq #(
   parameter int NUM_CH        = 8,
   parameter int CLKS_PER_BYTE = 8,
   localparam int CH_W = $clog2(NUM_CH),
   localparam int PH_W = $clog2(CLKS_PER_BYTE)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm_we,
   input  logic [NUM_CH-1:0] arm_mask,
   input  logic              cur_cnt_zero,
   input  logic              cur_alt,
   output logic              active,
   output logic [CH_W-1:0]   cur_ch,
   output logic              xfer,
   output logic              toggle,
   output logic [NUM_CH-1:0] armed
);

   logic [PH_W-1:0]   phase;
   logic [PH_W-1:0]   phase_nxt;
   logic              slot_end;
   logic [NUM_CH-1:0] rest;

   function automatic logic [CH_W-1:0] lowest(input logic [NUM_CH-1:0] m);
      logic [CH_W-1:0] idx;
      idx = '0;
      for (int i = NUM_CH - 1; i >= 0; i--) begin
         if (m[i]) idx = CH_W'(i);
      end
      return idx;
   endfunction

   assign slot_end = active && (phase == PH_W'(CLKS_PER_BYTE - 1));
   assign xfer     = active && (phase == '0);
   assign rest     = armed & ~(NUM_CH'(1) << cur_ch);

   if ((CLKS_PER_BYTE & (CLKS_PER_BYTE - 1)) == 0) begin : g_pow2_phase
      assign phase_nxt = phase + PH_W'(1);
   end else begin : g_cmp_phase
      assign phase_nxt = slot_end ? '0 : phase + PH_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         cur_ch <= '0;
         phase  <= '0;
         toggle <= 1'b0;
         armed  <= '0;
      end else if (!active) begin
         if (arm_we && (arm_mask != '0)) begin
            armed  <= arm_mask;
            active <= 1'b1;
            cur_ch <= lowest(arm_mask);
            phase  <= '0;
            toggle <= 1'b0;
         end
      end else begin
         phase <= phase_nxt;
         if (xfer && cur_alt) begin
            toggle <= ~toggle;
         end
         if (slot_end && cur_cnt_zero) begin
            armed  <= rest;
            toggle <= 1'b0;
            if (rest != '0) begin
               cur_ch <= lowest(rest);
            end else begin
               active <= 1'b0;
            end
         end
      end
   end

endmodule

// File: rtl/bdma_addrgen.sv
module bdma_addrgen
   import bdma_pkg::*;
(
   input  logic [PAT_W-1:0] pat,
   input  logic [7:0]       base_port,
   input  logic [23:0]      src,
   input  logic             toggle,
   output logic             alt,
   output logic [23:0]      src_addr,
   output logic [7:0]       port_idx
);

   assign alt      = (pat == PAT_ALTERNATE);
   assign src_addr = src;
   assign port_idx = base_port + ((alt && toggle) ? 8'd1 : 8'd0);

endmodule

// File: rtl/bdma_engine.sv
module bdma_engine
   import bdma_pkg::*;
#(
   parameter int NUM_CH        = 8,
   parameter int CLKS_PER_BYTE = 8,
   localparam int CH_W = $clog2(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CH_W-1:0]   cfg_ch,
   input  logic [2:0]        cfg_ofs,
   input  logic [7:0]        cfg_wdata,
   input  logic              arm_we,
   input  logic [NUM_CH-1:0] arm_mask,
   output logic              halt,
   output logic [NUM_CH-1:0] armed,
   output logic              src_rd,
   output logic [23:0]       src_addr,
   input  logic [7:0]        src_rdata,
   output logic              port_we,
   output logic [7:0]        port_idx,
   output logic [7:0]        port_wdata
);

   if (NUM_CH < 2) begin : g_bad_ch
      $error("bdma_engine: NUM_CH must be at least 2");
   end
   if (CLKS_PER_BYTE < 2) begin : g_bad_pitch
      $error("bdma_engine: CLKS_PER_BYTE must be at least 2");
   end

   chan_regs_t [NUM_CH-1:0] regs;
   chan_regs_t              cur;
   logic                    active;
   logic [CH_W-1:0]         cur_ch;
   logic                    xfer;
   logic                    toggle;
   logic                    cur_alt;

   assign cur = regs[cur_ch];

   bdma_regbank #(.NUM_CH(NUM_CH)) u_regbank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_we && !active),
      .wr_ch   (cfg_ch),
      .wr_ofs  (cfg_ofs),
      .wr_data (cfg_wdata),
      .step_en (xfer),
      .step_ch (cur_ch),
      .regs    (regs)
   );

   bdma_seq #(.NUM_CH(NUM_CH), .CLKS_PER_BYTE(CLKS_PER_BYTE)) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .arm_we       (arm_we),
      .arm_mask     (arm_mask),
      .cur_cnt_zero (cur.cnt == 16'd0),
      .cur_alt      (cur_alt),
      .active       (active),
      .cur_ch       (cur_ch),
      .xfer         (xfer),
      .toggle       (toggle),
      .armed        (armed)
   );

   bdma_addrgen u_addrgen (
      .pat       (cur.pat),
      .base_port (cur.port),
      .src       (cur.src),
      .toggle    (toggle),
      .alt       (cur_alt),
      .src_addr  (src_addr),
      .port_idx  (port_idx)
   );

   assign halt       = active;
   assign src_rd     = xfer;
   assign port_we    = xfer;
   assign port_wdata = src_rdata;

endmodule

// File: rtl/bdma_engine_chk.sv
module bdma_engine_chk #(
   parameter int NUM_CH        = 8,
   parameter int CLKS_PER_BYTE = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              halt,
   input logic [NUM_CH-1:0] armed,
   input logic              port_we
);

   logic [31:0] gap;
   logic        seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap  <= '0;
         seen <= 1'b0;
      end else if (!halt) begin
         gap  <= '0;
         seen <= 1'b0;
      end else if (port_we) begin
         gap  <= 32'd1;
         seen <= 1'b1;
      end else begin
         gap <= gap + 32'd1;
      end
   end

   // R3
   first_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(halt) |-> port_we);

   // R4
   byte_pitch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (halt && seen && port_we) |-> (gap == 32'(CLKS_PER_BYTE)));

   // R4
   no_early_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (halt && seen && !port_we) |-> (gap < 32'(CLKS_PER_BYTE)));

   // R5
   strobe_in_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      port_we |-> halt);

   // R6
   halt_has_work_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halt |-> (armed != '0));

   // R7
   armed_only_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (halt && $past(halt)) |-> ((armed & ~$past(armed)) == '0));

endmodule

bind bdma_engine bdma_engine_chk #(
   .NUM_CH        (NUM_CH),
   .CLKS_PER_BYTE (CLKS_PER_BYTE)
) u_chk (.*);

// File: tb/bdma_engine_bench.sv
module bdma_engine_bench;

   localparam int CPB = 8;

   typedef struct {
      int          cyc;
      logic [7:0]  port;
      logic [23:0] addr;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_ch = '0;
   logic [2:0]  cfg_ofs = '0;
   logic [7:0]  cfg_wdata = '0;
   logic        arm_we = 1'b0;
   logic [7:0]  arm_mask = '0;
   logic        arm2_we = 1'b0;
   logic        halt, halt2;
   logic [7:0]  armed, armed2;
   logic        src_rd, src_rd2;
   logic [23:0] src_addr, src_addr2;
   logic [7:0]  src_rdata, src_rdata2;
   logic        port_we, port_we2;
   logic [7:0]  port_idx, port_idx2;
   logic [7:0]  port_wdata, port_wdata2;

   int n_chk = 0;
   int n_err = 0;
   int cyc = 0;
   exp_t q[$];

   logic [2:0]  m_pat[8];
   logic [7:0]  m_port[8];
   logic [23:0] m_src[8];
   logic [15:0] m_cnt[8];

   int          l_cnt = 0;
   logic [23:0] l_last = '0;

   function automatic logic [7:0] memf(input logic [23:0] a);
      return a[7:0] + {a[14:8], a[15]} + (a[23:16] ^ 8'h5A);
   endfunction

   assign src_rdata  = memf(src_addr);
   assign src_rdata2 = memf(src_addr2);

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   bdma_engine u_bdma_engine (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_ofs(cfg_ofs),
      .cfg_wdata(cfg_wdata), .arm_we(arm_we), .arm_mask(arm_mask), .halt(halt),
      .armed(armed), .src_rd(src_rd), .src_addr(src_addr), .src_rdata(src_rdata),
      .port_we(port_we), .port_idx(port_idx), .port_wdata(port_wdata)
   );

   bdma_engine #(.CLKS_PER_BYTE(2)) u_bdma_engine_long (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_ofs(cfg_ofs),
      .cfg_wdata(cfg_wdata), .arm_we(arm2_we), .arm_mask(arm_mask), .halt(halt2),
      .armed(armed2), .src_rd(src_rd2), .src_addr(src_addr2), .src_rdata(src_rdata2),
      .port_we(port_we2), .port_idx(port_idx2), .port_wdata(port_wdata2)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // monitor: pops the scoreboard on each strobe
   always @(negedge clk) begin
      if (rst_n && port_we) begin
         if (q.size() == 0) begin
            chk(1'b0, "R4", "unexpected strobe", 32'(src_addr), 32'hFFFF_FFFF);
         end else begin
            exp_t e;
            e = q.pop_front();
            chk(cyc == e.cyc, "R4", "strobe cycle", 32'(cyc), 32'(e.cyc));
            chk(port_idx == e.port, "R9", "port index", 32'(port_idx), 32'(e.port));
            chk(src_addr == e.addr, "R8", "source address", 32'(src_addr), 32'(e.addr));
            chk(port_wdata == memf(e.addr), "R4", "port data", 32'(port_wdata),
                32'(memf(e.addr)));
            chk(src_rd == 1'b1, "R4", "read strobe", 32'(src_rd), 32'd1);
         end
      end
      if (rst_n && port_we2) begin
         l_cnt  <= l_cnt + 1;
         l_last <= src_addr2;
      end
   end

   // register write; the model follows only when the engine is idle (R11)
   task automatic cfg_write(input int ch, input logic [2:0] ofs, input logic [7:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_ch = 3'(ch); cfg_ofs = ofs; cfg_wdata = d;
      if (!halt) begin
         case (ofs)
            3'd0: m_pat[ch] = d[2:0];
            3'd1: m_port[ch] = d;
            3'd2: m_src[ch][7:0] = d;
            3'd3: m_src[ch][15:8] = d;
            3'd4: m_src[ch][23:16] = d;
            3'd5: m_cnt[ch][7:0] = d;
            3'd6: m_cnt[ch][15:8] = d;
            default: ;
         endcase
      end
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic program_ch(input int ch, input logic [7:0] pat, input logic [7:0] port,
                             input logic [23:0] src, input logic [15:0] cnt);
      cfg_write(ch, 3'd0, pat);
      cfg_write(ch, 3'd1, port);
      cfg_write(ch, 3'd2, src[7:0]);
      cfg_write(ch, 3'd3, src[15:8]);
      cfg_write(ch, 3'd4, src[23:16]);
      cfg_write(ch, 3'd5, cnt[7:0]);
      cfg_write(ch, 3'd6, cnt[15:8]);
   endtask

   // driver: pushes the expected bytes, arms, then follows halt and armed
   task automatic run(input logic [7:0] mask);
      int clear_at[8];
      int off;
      int k;
      int bad;
      logic [7:0] exp_arm;
      @(negedge clk);
      off = 0;
      for (int c = 0; c < 8; c++) begin
         clear_at[c] = 0;
         if (mask[c]) begin
            int n;
            n = (m_cnt[c] == 16'd0) ? 65536 : int'(m_cnt[c]);
            for (int b = 0; b < n; b++) begin
               exp_t e;
               e.cyc  = cyc + 1 + CPB * off;
               e.port = (m_pat[c] == 3'd1) ? m_port[c] + 8'(b & 1) : m_port[c];
               e.addr = {m_src[c][23:16], m_src[c][15:0] + 16'(b)};
               q.push_back(e);
               off++;
            end
            m_src[c][15:0] = m_src[c][15:0] + 16'(n);
            m_cnt[c] = 16'd0;
            clear_at[c] = CPB * off;
         end
      end
      arm_we = 1'b1; arm_mask = mask;
      @(negedge clk);
      arm_we = 1'b0;
      // R3 halt is up in the first cycle after the arm edge
      chk(halt == 1'b1, "R3", "halt after arm", 32'(halt), 32'd1);
      k = 0; bad = 0;
      while (halt && k < 200000) begin
         exp_arm = '0;
         for (int c = 0; c < 8; c++) exp_arm[c] = mask[c] && (k < clear_at[c]);
         if (armed != exp_arm) bad++;
         k++;
         @(negedge clk);
      end
      chk(bad == 0, "R7", "armed schedule mismatches", 32'(bad), 32'd0);
      chk(k == CPB * off, "R5", "halt length", 32'(k), 32'(CPB * off));
      chk(armed == 8'h00, "R7", "armed after burst", 32'(armed), 32'd0);
      chk(q.size() == 0, "R6", "bytes left unsent", 32'(q.size()), 32'd0);
      q.delete();
   endtask

   initial begin
      for (int c = 0; c < 8; c++) begin
         m_pat[c] = '0; m_port[c] = '0; m_src[c] = '0; m_cnt[c] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(halt == 1'b0, "R1", "halt at reset", 32'(halt), 32'd0);
      chk(armed == 8'h00, "R1", "armed at reset", 32'(armed), 32'd0);
      chk(port_we == 1'b0 && src_rd == 1'b0, "R1", "strobes at reset",
          32'({port_we, src_rd}), 32'd0);

      // R2 R9 single-port channel, offset 7 write must change nothing
      program_ch(2, 8'h00, 8'h21, 24'h7F0040, 16'd5);
      cfg_write(2, 3'd7, 8'hEE);
      run(8'h04);

      // R6 R9 three channels, alternating pattern with port wrap, pattern 3 as single
      program_ch(0, 8'h01, 8'h10, 24'h7E1000, 16'd3);
      program_ch(3, 8'h01, 8'hFF, 24'h010200, 16'd3);
      program_ch(7, 8'hF3, 8'h30, 24'h00ABCD, 16'd2);
      run(8'h89);

      // R8 low 16 bits wrap inside the bank
      program_ch(4, 8'h00, 8'h50, 24'h12FFFE, 16'd4);
      run(8'h10);

      // R11 writes and arm during a burst are dropped
      program_ch(5, 8'h00, 8'h40, 24'h020000, 16'd2);
      program_ch(6, 8'h01, 8'h60, 24'h030010, 16'd3);
      fork
         run(8'h40);
         begin
            repeat (3) @(negedge clk);
            cfg_we = 1'b1; cfg_ch = 3'd5; cfg_ofs = 3'd1; cfg_wdata = 8'h99;
            @(negedge clk);
            cfg_we = 1'b0;
            arm_we = 1'b1; arm_mask = 8'h20;
            @(negedge clk);
            arm_we = 1'b0;
         end
      join
      chk(armed == 8'h00, "R11", "arm during burst ignored", 32'(armed), 32'd0);
      run(8'h20);

      // R10 count 0 on the two-clock instance: 65536 bytes
      program_ch(1, 8'h00, 8'h70, 24'h050010, 16'd0);
      @(negedge clk);
      arm2_we = 1'b1; arm_mask = 8'h02;
      @(negedge clk);
      arm2_we = 1'b0;
      begin
         int k2;
         k2 = 0;
         while (halt2 && k2 < 190000) begin
            k2++;
            @(negedge clk);
         end
         chk(k2 == 131072, "R10", "halt length for count 0", 32'(k2), 32'd131072);
      end
      chk(l_cnt == 65536, "R10", "bytes for count 0", 32'(l_cnt), 32'd65536);
      chk(l_last == 24'h05000F, "R8", "last address after full wrap", 32'(l_last),
          32'h05000F);
      chk(armed2 == 8'h00, "R7", "armed after long burst", 32'(armed2), 32'd0);

      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (195000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule